// File: doc/BRIEF.md
# Interleaved IQ Sample Bridge

This block connects a host-side sample path, which carries I and Q as separate 16-bit signed words, to a transceiver that has only a 12-bit data bus, shared in time between I and Q. A one-bit select line runs alongside the bus in each direction. It is high while the I word is on the bus and low while the Q word is on the bus.

On transmit, the host presents an I/Q pair together with a one-cycle strobe. The block narrows each value to 12 bits with saturation. It then places I on the bus for one clock and the matching Q on the following clock. The I/Q alternation runs continuously. When no sample is waiting, both phases carry zero.

On receive, the block watches the interleaved words and their select line. It rebuilds each I/Q pair and widens both halves to 16 bits by sign extension. It then raises a valid strobe for one cycle per completed pair. A Q word that has no I word before it is discarded.

Top module: `iq_interleave_bridge`

## Requirements
- R1: While `rst` is high at a clock edge, `tx_sel`, `tx_word`, `rx_valid`, `rx_i` and `rx_q` are all zero on the following cycle. The first edge after `rst` falls is an I phase, so `tx_sel` goes to 1 on that edge.
- R2: Transmit narrowing is as follows. A 16-bit signed value in the range -2048..2047 keeps its low 12 bits. A value above 2047 becomes 12'h7FF. A value below -2048 becomes 12'h800.
- R3: `tx_sel` toggles on every clock edge after reset. A value of 1 marks an I word on `tx_word` and a value of 0 marks a Q word.
- R4: A sample strobe on an edge where the next phase is I puts the narrowed I on `tx_word` in the following cycle (with `tx_sel`=1). The narrowed Q follows in the cycle after that (with `tx_sel`=0).
- R5: With no strobe and no held sample, `tx_word` is zero during both the I phase and the Q phase.
- R6: A strobe on a Q-phase edge is held and sent at the next I phase. If another strobe arrives on that I-phase edge, the newer pair is sent and the held one is discarded.
- R7: Received 12-bit words are sign-extended to 16 bits. Bit 11 is copied into bits 15..12 of `rx_i` and `rx_q`.
- R8: An edge with `rx_sel`=0 that follows a captured I word completes a pair. In the next cycle, `rx_valid` is 1 for exactly one cycle and `rx_i`/`rx_q` show the pair. The outputs hold their values between pairs.
- R9: A word with `rx_sel`=0 that has no pending I word is dropped. It raises no valid strobe and leaves `rx_i`/`rx_q` unchanged.
- R10: When two I words arrive back to back, the later one is paired with the next Q word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both directions |
| rst | input | 1 | Synchronous reset, active high |
| tx_strobe | input | 1 | Host presents a transmit pair this cycle |
| tx_i | input | 16 | Host transmit I, signed |
| tx_q | input | 16 | Host transmit Q, signed |
| tx_word | output | 12 | Interleaved transmit bus word |
| tx_sel | output | 1 | High for I word, low for Q word (transmit) |
| rx_word | input | 12 | Interleaved receive bus word |
| rx_sel | input | 1 | High for I word, low for Q word (receive) |
| rx_valid | output | 1 | One-cycle strobe per rebuilt pair |
| rx_i | output | 16 | Rebuilt receive I, sign-extended |
| rx_q | output | 16 | Rebuilt receive Q, sign-extended |

## Verification
The assertions assume that `rst` is held high across at least one clock edge before any traffic, because the phase tracker has no defined value until then. They also assume that `tx_strobe` is a level sampled at the edge and carries no meaning beyond that cycle. On the receive side, every clock carries a word, so `rx_sel` is treated as always meaningful. The stimulus starts with reset held for several edges, changes inputs only on falling edges, and keeps receive idle as Q words with value zero, which the pairing logic is expected to drop.

// File: rtl/iqb_pkg.sv
package iqb_pkg;
  localparam int IQB_HOST_W = 16;
  localparam int IQB_LINE_W = 12;

  typedef enum logic {
    PH_Q = 1'b0,
    PH_I = 1'b1
  } iqb_phase_e;
endpackage

// File: rtl/iqb_tx_serializer.sv
module iqb_tx_serializer
  import iqb_pkg::*;
#(
  parameter int HOST_W = IQB_HOST_W,
  parameter int LINE_W = IQB_LINE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_strobe,
  input  logic [HOST_W-1:0] smp_i,
  input  logic [HOST_W-1:0] smp_q,
  output logic [LINE_W-1:0] line_word,
  output logic              line_isel
);
  localparam int SMAX = (2 ** (LINE_W - 1)) - 1;
  localparam int SMIN = -(2 ** (LINE_W - 1));
  localparam logic signed [HOST_W-1:0] HI_LIM = HOST_W'(SMAX);
  localparam logic signed [HOST_W-1:0] LO_LIM = HOST_W'(SMIN);

  function automatic logic [LINE_W-1:0] narrow_sat(input logic [HOST_W-1:0] v);
    logic signed [HOST_W-1:0] s;
    s = $signed(v);
    if (s > HI_LIM)      return LINE_W'(SMAX);
    else if (s < LO_LIM) return LINE_W'(SMIN);
    else                 return v[LINE_W-1:0];
  endfunction

  iqb_phase_e        ph_q;
  logic              pend_q;
  logic [HOST_W-1:0] hold_i, hold_q;
  logic [LINE_W-1:0] q_stage;

  // named internal events
  logic              i_phase;
  logic              take_now;
  logic              park_now;
  logic [HOST_W-1:0] src_i, src_q;

  always_comb begin
    i_phase  = (ph_q == PH_I);
    take_now = i_phase && (smp_strobe || pend_q);
    park_now = !i_phase && smp_strobe;
    src_i    = smp_strobe ? smp_i : hold_i;
    src_q    = smp_strobe ? smp_q : hold_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q      <= PH_I;
      pend_q    <= 1'b0;
      hold_i    <= '0;
      hold_q    <= '0;
      q_stage   <= '0;
      line_word <= '0;
      line_isel <= 1'b0;
    end else begin
      ph_q      <= i_phase ? PH_Q : PH_I;
      line_isel <= i_phase;
      if (i_phase) begin
        line_word <= take_now ? narrow_sat(src_i) : '0;
        q_stage   <= take_now ? narrow_sat(src_q) : '0;
      end else begin
        line_word <= q_stage;
      end
      if (park_now) begin
        hold_i <= smp_i;
        hold_q <= smp_q;
        pend_q <= 1'b1;
      end else if (take_now) begin
        pend_q <= 1'b0;
      end
    end
  end

  // R3: select alternates every cycle
  assert_sel_toggles_R3: assert property (@(posedge clk) disable iff (rst)
    line_isel |=> !line_isel);
  assert_sel_returns_R3: assert property (@(posedge clk) disable iff (rst | $past(rst))
    !line_isel |=> line_isel);

  // R5: idle I phase yields zero on both phases
  assert_idle_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (i_phase && !pend_q && !smp_strobe) |=> (line_word == '0) ##1 (line_word == '0));

  // R6: a held sample is consumed on the next I phase
  assert_pending_drains_R6: assert property (@(posedge clk) disable iff (rst)
    (pend_q && i_phase && !smp_strobe) |=> !pend_q);

  // R4: a taken sample appears with the I select
  assert_take_marks_i_R4: assert property (@(posedge clk) disable iff (rst)
    take_now |=> line_isel);
endmodule

// File: rtl/iqb_rx_deserializer.sv
module iqb_rx_deserializer
  import iqb_pkg::*;
#(
  parameter int HOST_W = IQB_HOST_W,
  parameter int LINE_W = IQB_LINE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LINE_W-1:0] line_word,
  input  logic              line_isel,
  output logic              pair_valid,
  output logic [HOST_W-1:0] pair_i,
  output logic [HOST_W-1:0] pair_q
);
  localparam int EXT_W = HOST_W - LINE_W;

  function automatic logic [HOST_W-1:0] widen_sext(input logic [LINE_W-1:0] w);
    return {{EXT_W{w[LINE_W-1]}}, w};
  endfunction

  logic              have_i;
  logic [LINE_W-1:0] i_hold;

  // named internal events
  logic pair_done;
  logic orphan_q;

  always_comb begin
    pair_done = !line_isel && have_i;
    orphan_q  = !line_isel && !have_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      have_i     <= 1'b0;
      i_hold     <= '0;
      pair_valid <= 1'b0;
      pair_i     <= '0;
      pair_q     <= '0;
    end else begin
      pair_valid <= 1'b0;
      if (line_isel) begin
        i_hold <= line_word;
        have_i <= 1'b1;
      end else if (pair_done) begin
        pair_i     <= widen_sext(i_hold);
        pair_q     <= widen_sext(line_word);
        pair_valid <= 1'b1;
        have_i     <= 1'b0;
      end
    end
  end

  // R8: valid is a single-cycle pulse
  assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    pair_valid |=> !pair_valid);

  // R9: an orphan Q raises no strobe and leaves outputs untouched
  assert_orphan_dropped_R9: assert property (@(posedge clk) disable iff (rst)
    orphan_q |=> (!pair_valid && $stable(pair_i) && $stable(pair_q)));

  // R10: an I word never completes a pair by itself
  assert_i_no_strobe_R10: assert property (@(posedge clk) disable iff (rst)
    line_isel |=> !pair_valid);
endmodule

// File: rtl/iq_interleave_bridge.sv
module iq_interleave_bridge
  import iqb_pkg::*;
#(
  parameter int HOST_W = IQB_HOST_W,
  parameter int LINE_W = IQB_LINE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_strobe,
  input  logic [HOST_W-1:0] tx_i,
  input  logic [HOST_W-1:0] tx_q,
  output logic [LINE_W-1:0] tx_word,
  output logic              tx_sel,
  input  logic [LINE_W-1:0] rx_word,
  input  logic              rx_sel,
  output logic              rx_valid,
  output logic [HOST_W-1:0] rx_i,
  output logic [HOST_W-1:0] rx_q
);
  iqb_tx_serializer #(.HOST_W(HOST_W), .LINE_W(LINE_W)) u_tx (
    .clk        (clk),
    .rst        (rst),
    .smp_strobe (tx_strobe),
    .smp_i      (tx_i),
    .smp_q      (tx_q),
    .line_word  (tx_word),
    .line_isel  (tx_sel)
  );

  iqb_rx_deserializer #(.HOST_W(HOST_W), .LINE_W(LINE_W)) u_rx (
    .clk        (clk),
    .rst        (rst),
    .line_word  (rx_word),
    .line_isel  (rx_sel),
    .pair_valid (rx_valid),
    .pair_i     (rx_i),
    .pair_q     (rx_q)
  );

  // R1: reset leaves both directions quiet
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!tx_sel && tx_word == '0 && !rx_valid));
endmodule

// File: tb/sim_iq_interleave_bridge.sv
module sim_iq_interleave_bridge;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tx_strobe = 1'b0;
  logic [15:0] tx_i = '0, tx_q = '0;
  logic [11:0] tx_word;
  logic        tx_sel;
  logic [11:0] rx_word = '0;
  logic        rx_sel = 1'b0;
  logic        rx_valid;
  logic [15:0] rx_i, rx_q;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  iq_interleave_bridge u0 (
    .clk(clk), .rst(rst),
    .tx_strobe(tx_strobe), .tx_i(tx_i), .tx_q(tx_q),
    .tx_word(tx_word), .tx_sel(tx_sel),
    .rx_word(rx_word), .rx_sel(rx_sel),
    .rx_valid(rx_valid), .rx_i(rx_i), .rx_q(rx_q)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] ref_narrow(input int v);
    int c;
    c = (v > 2047) ? 2047 : ((v < -2048) ? -2048 : v);
    return 12'(c);
  endfunction

  function automatic logic [15:0] ref_widen(input logic [11:0] w);
    int v;
    v = int'(w);
    if (v >= 2048) v = v - 4096;
    return 16'(v);
  endfunction

  // Wait at a falling edge until the next rising edge is an I phase.
  task automatic align_to_i();
    @(negedge clk);
    while (tx_sel !== 1'b0) @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(tx_sel == 1'b0,   "R1 tx_sel",   int'(tx_sel),   0);
    check(tx_word == 12'h0, "R1 tx_word",  int'(tx_word),  0);
    check(rx_valid == 1'b0, "R1 rx_valid", int'(rx_valid), 0);
    check(rx_i == 16'h0 && rx_q == 16'h0, "R1 rx pair", int'(rx_i), 0);
    rst = 1'b0;
    @(negedge clk);
    check(tx_sel == 1'b1, "R1 first phase is I", int'(tx_sel), 1);
  endtask

  task automatic t_tx_pair(input int vi, input int vq, input string tag);
    align_to_i();
    tx_strobe = 1'b1; tx_i = 16'(vi); tx_q = 16'(vq);
    @(negedge clk);
    tx_strobe = 1'b0;
    check(tx_sel == 1'b1 && tx_word == ref_narrow(vi), {tag, " I word"}, int'(tx_word), int'(ref_narrow(vi)));
    @(negedge clk);
    check(tx_sel == 1'b0 && tx_word == ref_narrow(vq), {tag, " Q word"}, int'(tx_word), int'(ref_narrow(vq)));
  endtask

  task automatic t_tx_idle();
    align_to_i();
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(tx_word == 12'h0, "R5 idle zero", int'(tx_word), 0);
      check(tx_sel == ((k % 2) == 0), "R3 alternation", int'(tx_sel), int'((k % 2) == 0));
    end
  endtask

  task automatic t_tx_pending();
    // single strobe on a Q-phase edge
    align_to_i();
    @(negedge clk);
    tx_strobe = 1'b1; tx_i = 16'd321; tx_q = -16'sd77;
    @(negedge clk);
    tx_strobe = 1'b0;
    check(tx_sel == 1'b0 && tx_word == 12'h0, "R6 held not sent yet", int'(tx_word), 0);
    @(negedge clk);
    check(tx_sel == 1'b1 && tx_word == ref_narrow(321), "R6 held I", int'(tx_word), int'(ref_narrow(321)));
    @(negedge clk);
    check(tx_word == ref_narrow(-77), "R6 held Q", int'(tx_word), int'(ref_narrow(-77)));
    // held pair replaced by a newer strobe
    align_to_i();
    @(negedge clk);
    tx_strobe = 1'b1; tx_i = 16'd11; tx_q = 16'd22;
    @(negedge clk);
    tx_i = 16'd500; tx_q = -16'sd600;
    @(negedge clk);
    tx_strobe = 1'b0;
    check(tx_word == ref_narrow(500), "R6 newer I wins", int'(tx_word), int'(ref_narrow(500)));
    @(negedge clk);
    check(tx_word == ref_narrow(-600), "R6 newer Q wins", int'(tx_word), int'(ref_narrow(-600)));
  endtask

  task automatic t_rx_pair(input logic [11:0] wi, input logic [11:0] wq, input string tag);
    rx_sel = 1'b1; rx_word = wi;
    @(negedge clk);
    check(rx_valid == 1'b0, "R10 no strobe on I", int'(rx_valid), 0);
    rx_sel = 1'b0; rx_word = wq;
    @(negedge clk);
    rx_word = 12'h0;
    check(rx_valid == 1'b1, "R8 valid after Q", int'(rx_valid), 1);
    check(rx_i == ref_widen(wi), {tag, " rx_i"}, int'(rx_i), int'(ref_widen(wi)));
    check(rx_q == ref_widen(wq), {tag, " rx_q"}, int'(rx_q), int'(ref_widen(wq)));
    @(negedge clk);
    check(rx_valid == 1'b0, "R8 one-cycle pulse", int'(rx_valid), 0);
    check(rx_i == ref_widen(wi), "R8 rx_i held", int'(rx_i), int'(ref_widen(wi)));
  endtask

  task automatic t_rx_orphan();
    logic [15:0] keep_i, keep_q;
    keep_i = rx_i; keep_q = rx_q;
    rx_sel = 1'b0; rx_word = 12'h5A5;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(rx_valid == 1'b0, "R9 orphan no strobe", int'(rx_valid), 0);
      check(rx_i == keep_i && rx_q == keep_q, "R9 outputs unchanged", int'(rx_q), int'(keep_q));
    end
    rx_word = 12'h0;
  endtask

  task automatic t_rx_double_i();
    rx_sel = 1'b1; rx_word = 12'h123;
    @(negedge clk);
    rx_word = 12'hABC;
    @(negedge clk);
    rx_sel = 1'b0; rx_word = 12'h00F;
    @(negedge clk);
    rx_word = 12'h0;
    check(rx_valid == 1'b1, "R10 pair completes", int'(rx_valid), 1);
    check(rx_i == ref_widen(12'hABC), "R10 later I used", int'(rx_i), int'(ref_widen(12'hABC)));
    check(rx_q == 16'h000F, "R10 Q value", int'(rx_q), 16'h000F);
  endtask

  initial begin
    t_reset();
    t_tx_idle();
    t_tx_pair(100, -5, "R4 in range");
    t_tx_pair(30000, -30000, "R2 clamp");
    t_tx_pair(2047, -2048, "R2 limits");
    t_tx_pair(2048, -2049, "R2 just beyond");
    t_tx_pending();
    t_tx_idle();
    t_rx_pair(12'h7FF, 12'h800, "R7 extremes");
    t_rx_pair(12'h001, 12'hFFF, "R7 small");
    t_rx_orphan();
    t_rx_double_i();
    t_rx_orphan();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule